// File: doc/BRIEF.md
# PLL Divider Chain with Test Output Selector

This block holds the digital dividers that sit around a phase-locked loop. The reference clock passes through a fixed power-of-two prescaler whose square-wave output feeds one input of a phase detector. The oscillator clock drives a programmable down-counter. That counter gives one terminal pulse per M oscillator cycles, and this pulse is the feedback input of the same detector. The oscillator clock also drives a post divider that produces the main output clock. The divider chain itself does not touch the phase detector or the oscillator.

The post divider takes a two-bit ratio code that is not monotonic. It gives a 50% duty output for ratios 2, 4 and 8, and it passes the oscillator clock straight through for ratio 1. A new ratio is applied only where the current output period ends, with the output low, so the output clock never carries a runt pulse. The feedback counter takes a new M only at its terminal count, so a period already under way always runs to its end.

A three-bit test mode selects what drives a single observation pin. The choices are the serial shift-register bit, a constant high or low, the prescaled reference, the feedback pulse divided by two, the output clock, the output clock divided by four, or a second feedback counter. That second counter is clocked from the serial clock instead of the oscillator, so the M path can be tested at low speed.

Top module: `pll_div_chain`

## Requirements
- R1: The prescaled reference output is low out of reset and changes level every 8 reference-clock rising edges (reference divided by 16, 50% duty).
- R2: The feedback pulse is high in the reset state and, after reset, in exactly one oscillator cycle out of every M. An M of 0 behaves as M = 1, which keeps the pulse high in every cycle.
- R3: The feedback counter samples M only on the oscillator edge that ends a pulse cycle. A change of M at any other time does not alter the period that is under way.
- R4: Ratio code 00 divides by 2, 01 by 4 and 10 by 8. For a ratio R the output is low for the first R/2 oscillator cycles of each period and high for the last R/2.
- R5: Ratio code 11 passes the oscillator clock to the output: the output is high in the high phase and low in the low phase of every oscillator cycle.
- R6: A new ratio code is applied only on the oscillator edge that ends the current output period, and on that edge the output is driven low. The output therefore shows no partial period.
- R7: Test mode 000 drives the test pin with the shift-register bit, mode 001 drives it high and mode 101 drives it low.
- R8: Test mode 010 drives the test pin with the prescaled reference, and mode 100 drives it with the main output clock.
- R9: Test mode 011 drives the test pin with a flop that is low out of reset and toggles on every oscillator edge that ends a feedback pulse cycle.
- R10: Test mode 110 drives the test pin with the equivalent toggle of a second M counter. That counter is clocked by serial-clock rising edges, uses the same M rules and is reset low.
- R11: Test mode 111 drives the test pin with bit 1 of a two-bit counter of output-clock rising edges, which is the output clock divided by 4. The counter is zero out of reset.
- R12: While reset is active, the output clock is low and both feedback toggles are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| rst_n | input | 1 | Asynchronous active-low reset for all dividers |
| ref_clk | input | 1 | Reference clock into the prescaler |
| vco_clk | input | 1 | Oscillator clock for the feedback counter and post divider |
| sclk | input | 1 | Serial clock, used as the clock of the test-mode M counter |
| m_val | input | M_W | Feedback divide value M |
| n_code | input | 2 | Post-divider ratio code |
| t_mode | input | 3 | Test-output selector |
| sr_bit | input | 1 | Serial shift-register output bit |
| ref_div_o | output | 1 | Prescaled reference for the phase detector |
| fb_pulse_o | output | 1 | Feedback terminal pulse for the phase detector |
| fout_o | output | 1 | Main output clock |
| test_o | output | 1 | Test observation output |

## Verification
Every ratio code is run with small M values (0, 1, 2, 3, 7) and with one in-range value (125). This separates off-by-one errors in the reload value from errors in the terminal decode. The output clock is sampled in both half-cycles, which tells the divided ratios apart from bypass. The test mode cycles through all eight codes while the chain runs, so a swapped multiplexer leg shows up at once. M is also changed in the middle of a period and again on a pulse cycle, to show that it is taken only at the terminal count. The ratio code is changed on almost every cycle, including moves into and out of bypass, to show that a new ratio waits for the end of the period. Finally, serial-clock pulses drive the low-speed counter while M changes, to show that it has its own period.

// File: rtl/pdc_pkg.sv
package pdc_pkg;

  typedef enum logic [2:0] {
    TM_SHIFT  = 3'd0,
    TM_HIGH   = 3'd1,
    TM_REF    = 3'd2,
    TM_FBHALF = 3'd3,
    TM_FOUT   = 3'd4,
    TM_LOW    = 3'd5,
    TM_SCLKFB = 3'd6,
    TM_FOUT4  = 3'd7
  } tmode_e;

  // log2 of the post-divide ratio for a ratio code (code 11 is bypass)
  function automatic logic [1:0] post_log2(input logic [1:0] code);
    case (code)
      2'b00:   return 2'd1;
      2'b01:   return 2'd2;
      2'b10:   return 2'd3;
      default: return 2'd0;
    endcase
  endfunction

  // effective feedback modulus: zero acts as one
  function automatic int unsigned eff_m(input int unsigned m);
    return (m == 0) ? 1 : m;
  endfunction

endpackage

// File: rtl/pdc_ref_div.sv
module pdc_ref_div #(
  parameter int LOG2 = 4
) (
  input  logic clk,
  input  logic rst_n,
  output logic ref_div
);
  logic [LOG2-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else        cnt <= cnt + 1'b1;
  end

  assign ref_div = cnt[LOG2-1];
endmodule

// File: rtl/pdc_fb_count.sv
module pdc_fb_count #(
  parameter int M_W = 9
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [M_W-1:0] m_val,
  output logic           term,
  output logic           half
);
  logic [M_W-1:0] cnt;
  logic [M_W-1:0] reload;

  assign term   = (cnt == '0);
  assign reload = (m_val == '0) ? '0 : m_val - M_W'(1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt  <= '0;
      half <= 1'b0;
    end else if (term) begin
      cnt  <= reload;
      half <= ~half;
    end else begin
      cnt  <= cnt - M_W'(1);
    end
  end
endmodule

// File: rtl/pdc_post_div.sv
module pdc_post_div #(
  parameter int CW = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] n_code,
  output logic       fout,
  output logic [1:0] n_act,
  output logic       wrap,
  output logic       div_q
);
  import pdc_pkg::*;

  localparam int IW = $clog2(CW);

  logic [CW-1:0] cnt;
  logic [1:0]    lg;
  logic [CW-1:0] last;
  logic [IW-1:0] bit_sel;
  logic          byp_g;

  assign lg      = post_log2(n_act);
  assign last    = (CW'(1) << lg) - CW'(1);
  assign wrap    = (cnt == last);
  assign bit_sel = IW'(lg) - IW'(1);
  assign div_q   = (lg == 2'd0) ? 1'b0 : cnt[bit_sel];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt   <= '0;
      n_act <= 2'b00;
    end else if (wrap) begin
      cnt   <= '0;
      n_act <= n_code;
    end else begin
      cnt   <= cnt + CW'(1);
    end
  end

  // bypass gate moves only while the clock is low
  always_ff @(negedge clk or negedge rst_n) begin
    if (!rst_n) byp_g <= 1'b0;
    else        byp_g <= (n_act == 2'b11);
  end

  assign fout = byp_g ? clk : div_q;
endmodule

// File: rtl/pdc_test_mux.sv
module pdc_test_mux (
  input  logic       rst_n,
  input  logic [2:0] t_mode,
  input  logic       sr_bit,
  input  logic       ref_div,
  input  logic       fb_half,
  input  logic       fout,
  input  logic       sclk_half,
  output logic       test_o
);
  import pdc_pkg::*;

  logic [1:0] f4_cnt;

  always_ff @(posedge fout or negedge rst_n) begin
    if (!rst_n) f4_cnt <= 2'd0;
    else        f4_cnt <= f4_cnt + 2'd1;
  end

  always_comb begin
    case (tmode_e'(t_mode))
      TM_SHIFT:  test_o = sr_bit;
      TM_HIGH:   test_o = 1'b1;
      TM_REF:    test_o = ref_div;
      TM_FBHALF: test_o = fb_half;
      TM_FOUT:   test_o = fout;
      TM_LOW:    test_o = 1'b0;
      TM_SCLKFB: test_o = sclk_half;
      default:   test_o = f4_cnt[1];
    endcase
  end
endmodule

// File: rtl/pll_div_chain.sv
module pll_div_chain #(
  parameter int M_W      = 9,
  parameter int REF_LOG2 = 4,
  parameter int PD_CW    = 3
) (
  input  logic           rst_n,
  input  logic           ref_clk,
  input  logic           vco_clk,
  input  logic           sclk,
  input  logic [M_W-1:0] m_val,
  input  logic [1:0]     n_code,
  input  logic [2:0]     t_mode,
  input  logic           sr_bit,
  output logic           ref_div_o,
  output logic           fb_pulse_o,
  output logic           fout_o,
  output logic           test_o
);
  localparam int N_FB = 2;

  logic [N_FB-1:0] fb_clk;
  logic [N_FB-1:0] fb_term;
  logic [N_FB-1:0] fb_half;
  logic [1:0]      n_act_w;
  logic            wrap_w;
  logic            div_w;

  assign fb_clk = {sclk, vco_clk};

  pdc_ref_div #(.LOG2(REF_LOG2)) u_ref (
    .clk(ref_clk), .rst_n(rst_n), .ref_div(ref_div_o)
  );

  // index 0: oscillator-clocked counter, index 1: serial-clock test counter
  for (genvar g = 0; g < N_FB; g++) begin : g_fb
    pdc_fb_count #(.M_W(M_W)) u_cnt (
      .clk(fb_clk[g]), .rst_n(rst_n), .m_val(m_val),
      .term(fb_term[g]), .half(fb_half[g])
    );
  end

  assign fb_pulse_o = fb_term[0];

  pdc_post_div #(.CW(PD_CW)) u_post (
    .clk(vco_clk), .rst_n(rst_n), .n_code(n_code), .fout(fout_o),
    .n_act(n_act_w), .wrap(wrap_w), .div_q(div_w)
  );

  pdc_test_mux u_tmux (
    .rst_n(rst_n), .t_mode(t_mode), .sr_bit(sr_bit), .ref_div(ref_div_o),
    .fb_half(fb_half[0]), .fout(fout_o), .sclk_half(fb_half[1]), .test_o(test_o)
  );
endmodule

// File: rtl/pdc_chk.sv
module pdc_chk #(
  parameter int M_W      = 9,
  parameter int REF_LOG2 = 4
) (
  input logic           rst_n,
  input logic           ref_clk,
  input logic           vco_clk,
  input logic [M_W-1:0] m_val,
  input logic [2:0]     t_mode,
  input logic           test_o,
  input logic           ref_div_o,
  input logic           fb_pulse_o,
  input logic [1:0]     n_act,
  input logic           div_q
);
  import pdc_pkg::*;

  localparam int HALF = 1 << (REF_LOG2 - 1);

  logic              prev_r;
  logic [REF_LOG2:0] run_r;
  logic [M_W:0]      gap;
  logic [M_W:0]      lat;
  logic              armed;

  always_ff @(posedge ref_clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_r <= 1'b0;
      run_r  <= '0;
    end else begin
      prev_r <= ref_div_o;
      run_r  <= (ref_div_o != prev_r) ? (REF_LOG2+1)'(1) : run_r + 1'b1;
    end
  end

  always_ff @(posedge vco_clk or negedge rst_n) begin
    if (!rst_n) begin
      gap   <= '0;
      lat   <= '0;
      armed <= 1'b0;
    end else if (fb_pulse_o) begin
      gap   <= (M_W+1)'(1);
      lat   <= (M_W+1)'(eff_m(int'(m_val)));
      armed <= 1'b1;
    end else begin
      gap   <= gap + 1'b1;
    end
  end

  AST_REF_HALF_PERIOD: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (ref_div_o != prev_r) |-> (run_r == (REF_LOG2+1)'(HALF))); // R1

  AST_REF_NO_LONG_LEVEL: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (run_r <= (REF_LOG2+1)'(HALF))); // R1

  AST_FB_SPACING: assert property (@(posedge vco_clk) disable iff (!rst_n)
    armed |-> (fb_pulse_o == (gap == lat))); // R3

  AST_N_AT_LOW: assert property (@(posedge vco_clk) disable iff (!rst_n)
    !$stable(n_act) |-> !div_q); // R6

  AST_TEST_HIGH: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (t_mode == 3'b001) |-> test_o); // R7

  AST_TEST_LOW: assert property (@(posedge ref_clk) disable iff (!rst_n)
    (t_mode == 3'b101) |-> !test_o); // R7
endmodule

bind pll_div_chain pdc_chk #(.M_W(M_W), .REF_LOG2(REF_LOG2)) u_chk (
  .rst_n(rst_n), .ref_clk(ref_clk), .vco_clk(vco_clk), .m_val(m_val),
  .t_mode(t_mode), .test_o(test_o), .ref_div_o(ref_div_o),
  .fb_pulse_o(fb_pulse_o), .n_act(n_act_w), .div_q(div_w)
);

// File: tb/pll_div_chain_tb.sv
`timescale 1ns/1ps
module pll_div_chain_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sclk = 1'b0;
  logic       sr_bit = 1'b0;
  logic [8:0] m_val = 9'd5;
  logic [1:0] n_code = 2'b00;
  logic [2:0] t_mode = 3'd0;
  wire        ref_div_o, fb_pulse_o, fout_o, test_o;

  always #2.5 clk = ~clk;

  pll_div_chain dut_i (
    .rst_n(rst_n), .ref_clk(clk), .vco_clk(clk), .sclk(sclk),
    .m_val(m_val), .n_code(n_code), .t_mode(t_mode), .sr_bit(sr_bit),
    .ref_div_o(ref_div_o), .fb_pulse_o(fb_pulse_o), .fout_o(fout_o), .test_o(test_o)
  );

  int n_chk = 0, n_fail = 0;
  bit done = 0;
  // bench model state
  int e, fb_next, s, snext, R, p, f4;
  bit fbh, sh, prev_lo, exp_hi, exp_lo;
  string fb_tag = "R2", n_tag = "";

  task automatic check(input logic got, input logic exp, input string tag, input string what);
    n_chk++;
    if (got !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0b expected %0b (edge %0d)", tag, what, got, exp, e);
    end
  endtask

  function automatic int ratio_of(input logic [1:0] c);
    case (c) 2'b00: return 2; 2'b01: return 4; 2'b10: return 8; default: return 1; endcase
  endfunction

  function automatic int modv(input logic [8:0] m);
    return (m == 9'd0) ? 1 : int'(m);
  endfunction

  function automatic bit lvl(input int pp, input int rr);
    return (rr == 1) ? 1'b0 : (pp >= rr / 2);
  endfunction

  function automatic bit exp_test();
    case (t_mode)
      3'd0: return sr_bit;
      3'd1: return 1'b1;
      3'd2: return ((e % 16) >= 8);
      3'd3: return fbh;
      3'd4: return exp_lo;
      3'd5: return 1'b0;
      3'd6: return sh;
      default: return ((f4 % 4) >= 2);
    endcase
  endfunction

  function automatic string test_tag();
    case (t_mode)
      3'd0, 3'd1, 3'd5: return "R7";
      3'd2, 3'd4: return "R8";
      3'd3: return "R9";
      3'd6: return "R10";
      default: return "R11";
    endcase
  endfunction

  task automatic do_reset();
    @(posedge clk); #1.25;
    rst_n = 1'b0;
    e = 0; fb_next = 0; s = 0; snext = 0; R = 2; p = 0; f4 = 0;
    fbh = 0; sh = 0; prev_lo = 0; exp_lo = 0;
    @(posedge clk); #3.75;
    check(ref_div_o, 1'b0, "R1", "reference low in reset");
    check(fb_pulse_o, 1'b1, "R2", "feedback pulse high in reset");
    check(fout_o, 1'b0, "R12", "output clock low in reset");
    t_mode = 3'd3; #0.1;
    check(test_o, 1'b0, "R12", "feedback toggle low in reset");
    t_mode = 3'd6; #0.1;
    check(test_o, 1'b0, "R12", "serial toggle low in reset");
    rst_n = 1'b1;
  endtask

  task automatic step(input bit pulse_s);
    int rold;
    @(posedge clk);
    rold = R;
    if (e == fb_next) begin fbh = ~fbh; fb_next = e + modv(m_val); end
    if (p == R - 1) begin p = 0; R = ratio_of(n_code); end else p++;
    e++;
    exp_hi = (rold == 1) ? 1'b1 : lvl(p, R);
    exp_lo = (R == 1) ? 1'b0 : lvl(p, R);
    if (!prev_lo && exp_hi) f4++;
    prev_lo = exp_lo;
    #1.25;
    check(fout_o, exp_hi, (n_tag != "") ? n_tag : ((R == 1 || rold == 1) ? "R5" : "R4"), "output clock high phase");
    #2.5;
    check(fout_o, exp_lo, (n_tag != "") ? n_tag : ((R == 1) ? "R5" : "R4"), "output clock low phase");
    check(ref_div_o, ((e % 16) >= 8), "R1", "prescaled reference");
    check(fb_pulse_o, (e == fb_next), fb_tag, "feedback pulse");
    check(test_o, exp_test(), test_tag(), "test output");
    if (pulse_s) begin
      #0.1 sclk = 1'b1;
      if (s == snext) begin sh = ~sh; snext = s + modv(m_val); end
      s++;
      #0.4 sclk = 1'b0;
      #0.2 check(test_o, sh, "R10", "serial-clock counter toggle");
    end
  endtask

  initial begin
    #1000000;
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL R12 watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    int mlist [6] = '{0, 1, 2, 3, 7, 125};
    // sweep every M in the list against every ratio code, cycling the test mode
    foreach (mlist[i]) begin
      for (int nc = 0; nc < 4; nc++) begin
        m_val = 9'(mlist[i]); n_code = 2'(nc);
        do_reset();
        for (int k = 0; k < ((mlist[i] > 10) ? 3 * mlist[i] : 40); k++) begin
          t_mode = 3'(k % 8); sr_bit = 1'((k >> 1) & 1);
          step(1'b0);
        end
      end
    end
    // R3: M changes in mid-period and on a pulse cycle
    fb_tag = "R3"; m_val = 9'd6; n_code = 2'b00;
    do_reset();
    for (int k = 0; k < 60; k++) begin
      t_mode = 3'd3;
      if (k == 2)  m_val = 9'd3;
      if (k == 8)  m_val = 9'd9;
      if (k == 17) m_val = 9'd2;
      if (k == 30) m_val = 9'd0;
      if (k == 35) m_val = 9'd4;
      step(1'b0);
    end
    fb_tag = "R2";
    // R6: ratio code moves almost every cycle, including into and out of bypass
    n_tag = "R6"; m_val = 9'd5;
    do_reset();
    for (int k = 0; k < 120; k++) begin
      t_mode = 3'(4 + 3 * (k % 2));
      n_code = 2'((k * 7 / 3 + k / 11) % 4);
      step(1'b0);
    end
    n_tag = "";
    // R10: serial-clock counter with its own period, M changed midway
    m_val = 9'd3; n_code = 2'b01;
    do_reset();
    for (int k = 0; k < 24; k++) begin
      t_mode = 3'd6;
      if (k == 10) m_val = 9'd4;
      step(1'b1);
    end
    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule